// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat cache-line burst. A burst starts when either of two active-low address-status strobes is sampled low on a rising clock edge. On that edge the external address is captured. The upper bits are then frozen for the whole burst. The two low bits form the starting point of the beat sequence.

Each later edge on which the active-low advance input is low moves the burst to its next beat. An edge with advance high and no strobe holds the current address, which suspends the burst. A static mode input picks the order of the beats. In linear order the low bits count upward modulo four from the start value. In interleaved order the low bits are the start value XORed with the beat number. After four beats the sequence returns to its start value, and it never carries into the upper bits.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset and before any load, `beat_addr` is all zeros.
- R2: A rising edge with `proc_start_n` low loads `ext_addr`, and `beat_addr` equals `ext_addr` after that edge.
- R3: A rising edge with `ctrl_start_n` low loads `ext_addr` in the same way as `proc_start_n`.
- R4: With `interleave` low, each advance edge adds 1 modulo 4 to `beat_addr[1:0]`. For example, a start of 1 gives 1,2,3,0.
- R5: With `interleave` high, `beat_addr[1:0]` equals the start value XOR the beat number 0,1,2,3. For example, a start of 2 gives 2,3,0,1.
- R6: After four advances, `beat_addr` is back at the loaded start address. A wrap never changes `beat_addr[17:2]`.
- R7: On an edge where either strobe is low, `adv_n` has no effect. The loaded address appears unchanged, as beat 0.
- R8: An edge with `adv_n` high and both strobes high leaves `beat_addr` unchanged.
- R9: Bits [17:2] of `beat_addr` keep the value captured at load, even if `ext_addr` changes during the burst.
- R10: `interleave` acts combinationally. Changing it between edges changes `beat_addr` at once to the order it selects, for the current beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proc_start_n | input | 1 | Processor start strobe, active low |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| interleave | input | 1 | 1 = XOR beat order, 0 = linear beat order |
| ext_addr | input | 18 | External start address |
| beat_addr | output | 18 | Address of the current beat |

## Verification
The hardest case to reach is an edge that carries a load and an advance together, while `ext_addr` is also changing. The stimulus holds `adv_n` low across the strobe edges. It then shows that the first address out is the raw external address, not its successor. A start value of 3 under an all-ones upper field drives the linear count through its wrap. This shows that no carry leaks upward. Changing `ext_addr` in mid-burst exposes any path that re-reads the external bits after the load.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  parameter int unsigned BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  // linear order: start plus beat number, modulo the burst length
  function automatic beat_t lin_beat(input beat_t start, input beat_t beat);
    return beat_t'(start + beat);
  endfunction

  // interleaved order: start with beat number folded in by XOR
  function automatic beat_t ilv_beat(input beat_t start, input beat_t beat);
    return start ^ beat;
  endfunction
endpackage

// File: rtl/bseq_load_ctrl.sv
module bseq_load_ctrl (
  input  logic proc_start_n,
  input  logic ctrl_start_n,
  input  logic adv_n,
  output logic load_evt,
  output logic step_evt
);
  // either start strobe loads; a load masks the advance
  always_comb begin
    load_evt = ~proc_start_n | ~ctrl_start_n;
    step_evt = ~load_evt & ~adv_n;
  end
endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt
  import bseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_evt,
  input  logic  step_evt,
  output beat_t beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat <= '0;
    else if (load_evt) beat <= '0;
    else if (step_evt) beat <= beat_t'(beat + 1'b1);
  end

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (beat == '0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (beat == beat_t'($past(beat) + 1'b1)));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> $stable(beat));
endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output beat_t             start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (load_evt) begin
      upper_q <= ext_addr[ADDR_W-1:BEAT_W];
      start_q <= ext_addr[BEAT_W-1:0];
    end
  end

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(upper_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              adv_n,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic            load_evt;
  logic            step_evt;
  beat_t           beat;
  beat_t           start_q;
  beat_t           low_bits;
  logic [UP_W-1:0] upper_q;

  bseq_load_ctrl u_ctrl (
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .adv_n        (adv_n),
    .load_evt     (load_evt),
    .step_evt     (step_evt)
  );

  bseq_beat_cnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat     (beat)
  );

  bseq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .ext_addr (ext_addr),
    .upper_q  (upper_q),
    .start_q  (start_q)
  );

  always_comb begin
    low_bits  = interleave ? ilv_beat(start_q, beat) : lin_beat(start_q, beat);
    beat_addr = {upper_q, low_bits};
  end

  // R2
  load_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (beat_addr == $past(ext_addr)));

  // R8
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && adv_n) |=> (!$stable(interleave) || $stable(beat_addr)));

  // R6
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> $stable(beat_addr[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 18;

  typedef struct {
    logic [AW-1:0] exp;
    string         req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_start_n = 1'b1;
  logic          ctrl_start_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          interleave = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] beat_addr;

  int n_chk = 0;
  int n_bad = 0;
  item_t sb[$];

  // bench-side reference state
  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_st = '0;
  int            m_bt = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk (clk), .rst_n (rst_n), .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n), .adv_n (adv_n), .interleave (interleave),
    .ext_addr (ext_addr), .beat_addr (beat_addr)
  );

  function automatic logic [AW-1:0] ref_addr(input logic mode);
    logic [1:0] b;
    logic [1:0] lo;
    b = 2'(m_bt);
    if (mode) lo = {m_st[1] ^ b[1], m_st[0] ^ b[0]};
    else      lo = 2'((int'(m_st) + m_bt) % 4);
    return {m_up, lo};
  endfunction

  task automatic check(input logic [AW-1:0] exp, input string req);
    n_chk++;
    if (beat_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, beat_addr, exp);
    end
  endtask

  // driver: set inputs in low phase, update model at edge, queue expectation
  task automatic cyc(input logic ps, input logic cs, input logic adv,
                     input logic mode, input logic [AW-1:0] a, input string req);
    item_t it;
    @(negedge clk);
    proc_start_n = ps; ctrl_start_n = cs; adv_n = adv;
    interleave = mode; ext_addr = a;
    @(posedge clk);
    if (!ps || !cs) begin
      m_up = a[AW-1:2]; m_st = a[1:0]; m_bt = 0;
    end else if (!adv) begin
      m_bt = (m_bt + 1) % 4;
    end
    it.exp = ref_addr(mode);
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compare in the high phase after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.exp, it.req);
      end
    end
  end

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check('0, "R1");
    @(negedge clk); rst_n = 1'b1;
    #3; check('0, "R1");

    // R2: processor load, then linear advances R4 and wrap R6
    cyc(0, 1, 1, 0, 18'h25D1, "R2");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 18'h0, "R4");
    cyc(1, 1, 0, 0, 18'h0, "R6");      // back at start 1
    // R8: suspend, with ext_addr noise
    cyc(1, 1, 1, 0, 18'h3FFFF, "R8");
    cyc(1, 1, 1, 0, 18'h00000, "R8");
    cyc(1, 1, 0, 0, 18'h0, "R4");

    // R3/R7: controller load with advance low, interleaved R5
    cyc(1, 0, 0, 1, 18'h1ABCE, "R7");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1, 18'h3F00 + 18'(i), "R5");
    cyc(1, 1, 0, 1, 18'h2AAAA, "R9");  // wrapped, upper kept
    // R2/R7: processor load with advance low
    cyc(0, 1, 0, 1, 18'h00033, "R7");
    cyc(1, 1, 0, 1, 18'h0, "R5");
    // R3 plain, both strobes at once
    cyc(1, 0, 1, 0, 18'h12346, "R3");
    cyc(0, 0, 0, 0, 18'h0BEEF, "R3");

    // R6: all-ones upper, linear wrap must not carry
    cyc(0, 1, 1, 0, 18'h3FFFF, "R2");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 18'h0, "R6");
    cyc(1, 1, 0, 0, 18'h0, "R6");       // beat 1 -> low bits 0, upper kept

    // R10: mode change between edges, start 3 at beat 1
    cyc(1, 1, 1, 0, 18'h0, "R8");
    @(negedge clk);
    interleave = 1'b1; #2;
    check(ref_addr(1'b1), "R10");      // 3^1 = 2
    interleave = 1'b0; #2;
    check(ref_addr(1'b0), "R10");      // 3+1 = 0
    cyc(1, 1, 1, 1, 18'h0, "R10");

    @(posedge clk); #8;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule